// File: doc/BRIEF.md
# Bus-Master Route Table

This block holds one routing entry per bus-master slot and tells the translation datapath where each master's traffic goes. Software programs every slot through a 32-bit register port. A slot either sends its master to one of the translation contexts, or to the segment-table path, or lets the traffic bypass translation. Each slot also carries two 8-bit address-space identifiers, an optional fixed upper-address value, and a flush command for that master's micro-TLB.

The lookup port takes a slot index and answers in the same cycle, with no register in the path. It returns the translate-enable bit, a target code, the context number, the two identifiers, the fixed-address fields and a route-error flag. A flush request becomes a single-cycle pulse on the output bit that belongs to the slot.

Top module: `utlb_route_table`

## Requirements
- R1: After reset, every register reads 0, every lookup reports bypass (target code 2) with translation off, and every flush output is low.
- R2: The control register of slot n is at byte address 0x300 + 16·n. Its fields are: bit 0 translate-enable, bits 7:4 select, bits 23:16 fixed address value, bit 31 fixed-address enable. A read returns the stored fields. Bit 1 and every other unused bit read as 0.
- R3: The identifier register of slot n is at 0x300 + 16·n + 8. Bits 7:0 hold identifier 0 and bits 15:8 hold identifier 1. A read returns both, and bits 31:16 read as 0. The lookup returns both identifiers of the selected slot.
- R4: With translate-enable set and a select value of 0 to 3, the lookup reports target code 0 and returns the select value as the context number.
- R5: With translate-enable set and a select value of 8, the lookup reports target code 1, the segment-table path.
- R6: With translate-enable clear, the lookup reports target code 2 and translation off, whatever the select value. No route error is raised.
- R7: With translate-enable set and any other select value, the lookup reports target code 3 and raises the route-error flag.
- R8: Writing a 1 to bit 1 of slot n's control register drives flush bit n high for exactly the one cycle after the write. The flush bit never reads back as 1.
- R9: Writing 0 to a slot's control register turns translation off for that slot.
- R10: Writes to addresses outside the slot window, or to offsets 4 and 12 inside a slot, change no state and raise no flush. Reads from those addresses return 0.
- R11: Lookup outputs are combinational in the slot index and show the register values written on the most recent clock edge. This includes the fixed-address fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| lk_slot_i | input | 5 | Lookup slot index |
| lk_xlate_en_o | output | 1 | Translation enabled for the slot |
| lk_target_o | output | 2 | 0 context, 1 segment table, 2 bypass, 3 invalid |
| lk_ctx_o | output | 2 | Context number when the target is a context |
| lk_route_err_o | output | 1 | Invalid select value on an enabled slot |
| lk_asid0_o | output | 8 | Identifier 0 |
| lk_asid1_o | output | 8 | Identifier 1 |
| lk_fix_en_o | output | 1 | Fixed-address extension enabled |
| lk_fix_addr_o | output | 8 | Fixed address value |
| flush_o | output | 32 | Per-slot micro-TLB flush pulse |

## Verification
The assertions rely on the register port performing at most one write per cycle and on write addresses staying word-aligned. The flush one-hot property and the rule that a write decodes to exactly one offset both depend on this. The bench therefore issues writes singly, one per negative-edge window, and uses only aligned addresses, including in the out-of-window cases. Lookup indices always stay below the slot count.

// File: rtl/utlb_route_pkg.sv
package utlb_route_pkg;
  localparam int SEL_W  = 4;
  localparam int FIX_W  = 8;
  localparam int ASID_W = 8;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    TGT_CTX     = 2'd0,
    TGT_PMB     = 2'd1,
    TGT_BYPASS  = 2'd2,
    TGT_INVALID = 2'd3
  } target_e;

  typedef struct packed {
    logic             fix_en;
    logic [FIX_W-1:0] fix_addr;
    logic [SEL_W-1:0] sel;
    logic             en;
  } slot_ctl_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid1;
    logic [ASID_W-1:0] asid0;
  } slot_asid_t;
endpackage

// File: rtl/utlb_route_slot.sv
module utlb_route_slot
  import utlb_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              asid_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output slot_ctl_t         ctl_o,
  output slot_asid_t        asid_o,
  output logic              flush_o
);
  slot_ctl_t  ctl_q;
  slot_asid_t asid_q;
  logic       flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      asid_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= ctl_we_i & wdata_i[1];
      if (ctl_we_i) begin
        ctl_q.en       <= wdata_i[0];
        ctl_q.sel      <= wdata_i[7:4];
        ctl_q.fix_addr <= wdata_i[23:16];
        ctl_q.fix_en   <= wdata_i[31];
      end
      if (asid_we_i) asid_q <= wdata_i[15:0];
    end
  end

  assign ctl_o   = ctl_q;
  assign asid_o  = asid_q;
  assign flush_o = flush_q;

  p_flush_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(ctl_we_i && wdata_i[1]));

  p_clear_disables_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i == '0) |=> !ctl_o.en);

  p_asid_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asid_we_i |=> $stable(asid_o));
endmodule

// File: rtl/utlb_route_decode.sv
module utlb_route_decode
  import utlb_route_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int PMB_SEL = 8,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  slot_ctl_t        ctl_i,
  output logic             xlate_en_o,
  output target_e          target_o,
  output logic [CTX_W-1:0] ctx_o,
  output logic             err_o
);
  always_comb begin
    xlate_en_o = ctl_i.en;
    ctx_o      = '0;
    err_o      = 1'b0;
    if (!ctl_i.en) begin
      target_o = TGT_BYPASS;
    end else if (32'(ctl_i.sel) < NUM_CTX) begin
      target_o = TGT_CTX;
      ctx_o    = ctl_i.sel[CTX_W-1:0];
    end else if (32'(ctl_i.sel) == PMB_SEL) begin
      target_o = TGT_PMB;
    end else begin
      target_o = TGT_INVALID;
      err_o    = 1'b1;
    end
  end
endmodule

// File: rtl/utlb_route_table.sv
module utlb_route_table
  import utlb_route_pkg::*;
#(
  parameter int          NUM_SLOTS   = 32,
  parameter int          NUM_CTX     = 4,
  parameter int          PMB_SEL     = 8,
  parameter int          ADDR_W      = 12,
  parameter int          SLOT_STRIDE = 16,
  parameter int          ASID_OFS    = 8,
  parameter logic [11:0] BASE_ADDR   = 12'h300,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int SLOT_SH  = $clog2(SLOT_STRIDE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [IDX_W-1:0]  lk_slot_i,
  output logic              lk_xlate_en_o,
  output logic [1:0]        lk_target_o,
  output logic [CTX_W-1:0]  lk_ctx_o,
  output logic              lk_route_err_o,
  output logic [ASID_W-1:0] lk_asid0_o,
  output logic [ASID_W-1:0] lk_asid1_o,
  output logic              lk_fix_en_o,
  output logic [FIX_W-1:0]  lk_fix_addr_o,
  output logic [NUM_SLOTS-1:0] flush_o
);
  localparam logic [ADDR_W-1:0] WIN_LEN = ADDR_W'(NUM_SLOTS * SLOT_STRIDE);
  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0]  off;
  logic               in_win, is_ctl, is_asid;
  logic [IDX_W-1:0]   acc_idx;
  logic [SLOT_SH-1:0] sub;

  assign off     = reg_addr_i - BASE;
  assign in_win  = off < WIN_LEN;
  assign acc_idx = off[SLOT_SH +: IDX_W];
  assign sub     = off[SLOT_SH-1:0];
  assign is_ctl  = in_win && sub == '0;
  assign is_asid = in_win && sub == SLOT_SH'(ASID_OFS);

  slot_ctl_t  ctl  [NUM_SLOTS];
  slot_asid_t asid [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    utlb_route_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_we_i  (reg_we_i && is_ctl  && acc_idx == IDX_W'(i)),
      .asid_we_i (reg_we_i && is_asid && acc_idx == IDX_W'(i)),
      .wdata_i   (reg_wdata_i),
      .ctl_o     (ctl[i]),
      .asid_o    (asid[i]),
      .flush_o   (flush_o[i])
    );
  end

  // Register readback; flush bit is never stored so reads 0
  always_comb begin
    reg_rdata_o = '0;
    if (is_ctl)
      reg_rdata_o = {ctl[acc_idx].fix_en, 7'd0, ctl[acc_idx].fix_addr, 8'd0,
                     ctl[acc_idx].sel, 3'd0, ctl[acc_idx].en};
    else if (is_asid)
      reg_rdata_o = {16'd0, asid[acc_idx]};
  end

  slot_ctl_t  lk_ctl;
  slot_asid_t lk_asid;
  target_e    lk_tgt;

  always_comb begin
    lk_ctl  = '0;
    lk_asid = '0;
    if (32'(lk_slot_i) < NUM_SLOTS) begin
      lk_ctl  = ctl[lk_slot_i];
      lk_asid = asid[lk_slot_i];
    end
  end

  utlb_route_decode #(.NUM_CTX(NUM_CTX), .PMB_SEL(PMB_SEL)) u_decode (
    .ctl_i      (lk_ctl),
    .xlate_en_o (lk_xlate_en_o),
    .target_o   (lk_tgt),
    .ctx_o      (lk_ctx_o),
    .err_o      (lk_route_err_o)
  );

  assign lk_target_o   = lk_tgt;
  assign lk_asid0_o    = lk_asid.asid0;
  assign lk_asid1_o    = lk_asid.asid1;
  assign lk_fix_en_o   = lk_ctl.fix_en;
  assign lk_fix_addr_o = lk_ctl.fix_addr;

  p_bypass_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_xlate_en_o |-> (lk_target_o == TGT_BYPASS && !lk_route_err_o));

  p_err_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_route_err_o |-> lk_xlate_en_o);

  p_pmb_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_target_o == TGT_PMB) |-> lk_xlate_en_o);

  p_flush_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flush_o));

  p_no_flush_stray_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && is_ctl) |=> flush_o == '0);
endmodule

// File: tb/utlb_route_table_bench.sv
module utlb_route_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  lk_slot = '0;
  logic        xlate_en, route_err, fix_en;
  logic [1:0]  target, ctx;
  logic [7:0]  asid0, asid1, fix_addr;
  logic [31:0] flush;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  utlb_route_table u_utlb_route_table (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lk_slot_i(lk_slot),
    .lk_xlate_en_o(xlate_en), .lk_target_o(target), .lk_ctx_o(ctx),
    .lk_route_err_o(route_err), .lk_asid0_o(asid0), .lk_asid1_o(asid1),
    .lk_fix_en_o(fix_en), .lk_fix_addr_o(fix_addr), .flush_o(flush)
  );

  function automatic logic [11:0] ctl_a(int n);  return 12'(12'h300 + 16*n);     endfunction
  function automatic logic [11:0] asid_a(int n); return 12'(12'h300 + 16*n + 8); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    addr = a; #1; check(tag, rdata, exp);
  endtask

  task automatic lk_check(string tag, int n, logic en, logic [1:0] tg, logic [1:0] cx, logic er);
    lk_slot = 5'(n); #1;
    check({tag, " en"}, 32'(xlate_en), 32'(en));
    check({tag, " target"}, 32'(target), 32'(tg));
    check({tag, " ctx"}, 32'(ctx), 32'(cx));
    check({tag, " err"}, 32'(route_err), 32'(er));
  endtask

  task automatic t_reset;
    rd_check("R1 ctl0", ctl_a(0), 0);
    rd_check("R1 ctl31", ctl_a(31), 0);
    rd_check("R1 asid5", asid_a(5), 0);
    lk_check("R1 lookup0", 0, 1'b0, 2'd2, 2'd0, 1'b0);
    check("R1 flush", flush, 0);
  endtask

  task automatic t_ctx;
    wr(ctl_a(3), 32'h0000_0021);
    wr(ctl_a(31), 32'h80AB_0031);
    rd_check("R2 readback31", ctl_a(31), 32'h80AB_0031);
    lk_check("R4 slot3", 3, 1'b1, 2'd0, 2'd2, 1'b0);
    lk_check("R11 slot31", 31, 1'b1, 2'd0, 2'd3, 1'b0);
    check("R11 fix_en", 32'(fix_en), 1);
    check("R11 fix_addr", 32'(fix_addr), 32'hAB);
    lk_slot = 5'd3; #1;
    check("R11 switch fix_en", 32'(fix_en), 0);
  endtask

  task automatic t_pmb;
    wr(ctl_a(10), 32'h0000_0081);
    lk_check("R5 slot10", 10, 1'b1, 2'd1, 2'd0, 1'b0);
  endtask

  task automatic t_bypass;
    wr(ctl_a(12), 32'h0000_0080);
    lk_check("R6 sel8 off", 12, 1'b0, 2'd2, 2'd0, 1'b0);
    wr(ctl_a(12), 32'h0000_00F0);
    lk_check("R6 selF off", 12, 1'b0, 2'd2, 2'd0, 1'b0);
  endtask

  task automatic t_invalid;
    wr(ctl_a(14), 32'h0000_0041);
    lk_check("R7 sel4", 14, 1'b1, 2'd3, 2'd0, 1'b1);
    wr(ctl_a(14), 32'h0000_0091);
    lk_check("R7 sel9", 14, 1'b1, 2'd3, 2'd0, 1'b1);
    wr(ctl_a(7), 32'hFFFF_FFFF);
    check("R8 flush from all-ones", flush, 32'h0000_0080);
    rd_check("R2 all-ones readback", ctl_a(7), 32'h80FF_00F1);
  endtask

  task automatic t_flush;
    wr(ctl_a(20), 32'h0000_0003);
    check("R8 pulse high", flush, 32'h0010_0000);
    rd_check("R8 bit1 reads 0", ctl_a(20), 32'h0000_0001);
    @(negedge clk);
    check("R8 pulse low", flush, 0);
  endtask

  task automatic t_disable;
    wr(ctl_a(3), 32'h0);
    lk_check("R9 slot3 off", 3, 1'b0, 2'd2, 2'd0, 1'b0);
    rd_check("R9 readback", ctl_a(3), 0);
  endtask

  task automatic t_asid;
    wr(asid_a(9), 32'hFFFF_5A3C);
    rd_check("R3 readback", asid_a(9), 32'h0000_5A3C);
    lk_slot = 5'd9; #1;
    check("R3 asid0", 32'(asid0), 32'h3C);
    check("R3 asid1", 32'(asid1), 32'h5A);
  endtask

  task automatic t_ignored;
    wr(12'h2FC, 32'hFFFF_FFFF);
    check("R10 flush below", flush, 0);
    wr(12'h304, 32'hFFFF_FFFF);
    check("R10 flush ofs4", flush, 0);
    wr(12'h30C, 32'hFFFF_FFFF);
    wr(12'h500, 32'hFFFF_FFFF);
    check("R10 flush above", flush, 0);
    rd_check("R10 ctl0", ctl_a(0), 0);
    rd_check("R10 asid0", asid_a(0), 0);
    rd_check("R10 read ofs4", 12'h304, 0);
    rd_check("R10 read above", 12'h500, 0);
    lk_check("R10 slot0", 0, 1'b0, 2'd2, 2'd0, 1'b0);
    rd_check("R10 ctl1", ctl_a(1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctx;
    t_pmb;
    t_bypass;
    t_invalid;
    t_flush;
    t_disable;
    t_asid;
    t_ignored;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule